// File: doc/BRIEF.md
# Triggered DMA Request Generator Channel

This block is one channel of a DMA request generator. Once enabled, it waits for a qualified trigger event, a single-cycle pulse from trigger edge logic outside this block. On that event it raises a request towards a DMA controller and keeps requesting until a programmed number of requests has been served. The number is the count field plus one. The channel then goes quiet until the next trigger. The DMA controller signals each served request with a one-cycle served pulse. The channel drops its request for one cycle and raises it again while requests remain in the burst.

If a trigger arrives while a burst is still running, the trigger is not honoured as a new burst. Instead it sets a sticky overrun flag. Software clears the flag with a one-cycle clear strobe. An interrupt enable gates the flag onto the overrun interrupt line. Dropping the enable at any point returns the channel to idle and withdraws any pending request. The count field is meant to change only while the channel is disabled, and it is captured when a burst starts.

Top module: `rqgen_channel`

## Requirements
- R1: While reset is high and in the first cycle after it, dma_req, ovr_flag and ovr_irq are 0.
- R2: While gen_en is 0, trig_evt has no effect: dma_req stays 0 and ovr_flag does not change.
- R3: A trig_evt pulse sampled with gen_en=1 while the channel is idle raises dma_req in the next cycle.
- R4: A dma_served pulse sampled while dma_req=1 drops dma_req in the next cycle. If requests remain in the burst, dma_req rises again one cycle after that.
- R5: Each accepted trigger yields exactly req_count+1 served requests, after which dma_req stays 0. req_count=0 yields one request.
- R6: A dma_served pulse sampled while dma_req=0 is ignored and does not shorten the burst.
- R7: A trig_evt sampled with gen_en=1 while a burst runs sets ovr_flag in the next cycle. The running burst continues with its remaining requests unchanged.
- R8: ovr_flag stays 1 until an ovr_clr pulse is sampled, which clears it in the next cycle. When an overrun and ovr_clr happen in the same cycle, the flag is set.
- R9: ovr_irq is 1 exactly when ovr_flag=1 and ovr_ie=1.
- R10: gen_en sampled 0 during a burst drops dma_req in the next cycle and abandons the burst. The next accepted trigger starts a full burst of req_count+1 requests.
- R11: A trigger sampled in the same cycle as the serve of the last request counts as an overrun. The burst ends and no new burst starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Channel enable |
| req_count | input | CNT_W | Requests per burst minus one |
| trig_evt | input | 1 | Qualified trigger event, one-cycle pulse |
| dma_served | input | 1 | Served indication from the DMA controller, one-cycle pulse |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| ovr_ie | input | 1 | Overrun interrupt enable |
| dma_req | output | 1 | Generated DMA request |
| ovr_flag | output | 1 | Sticky trigger overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The assertions check the cycle-level relations on every cycle. These are: the request rises after an accepted trigger, it falls after a serve, it returns after the one-cycle gap, it stays silent while disabled, and the overrun flag sets, holds and clears as required. The burst length itself is a property of many cycles and depends on the captured count. Only the bench scenarios can show it, by counting served requests for several counts and serve latencies. The same applies to burst restart after an enable drop, serves ignored in the gap, and the coincidence of a trigger with the final serve.

// File: rtl/rqgen_pkg.sv
package rqgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } rqgen_state_e;

    typedef struct packed {
        logic start;
        logic take;
        logic ovr_evt;
    } rqgen_ctl_t;

    function automatic logic is_busy(input rqgen_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/rqgen_counter.sv
module rqgen_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec && remaining != '0) begin
            remaining <= remaining - 1'b1;
        end
    end

    assign last = (remaining == '0);
endmodule

// File: rtl/rqgen_fsm.sv
module rqgen_fsm
    import rqgen_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         trig,
    input  logic         served,
    input  logic         last,
    output rqgen_state_e state,
    output rqgen_ctl_t   ctl
);
    rqgen_state_e state_nx;

    always_comb begin
        ctl.start   = en && trig && !is_busy(state);
        ctl.take    = en && served && (state == ST_REQ);
        ctl.ovr_evt = en && trig && is_busy(state);
    end

    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (ctl.start) state_nx = ST_REQ;
                ST_REQ:  if (ctl.take)  state_nx = last ? ST_IDLE : ST_GAP;
                ST_GAP:  state_nx = ST_REQ;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end
endmodule

// File: rtl/rqgen_ovr.sv
module rqgen_ovr (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign irq = flag & ie;
endmodule

// File: rtl/rqgen_channel.sv
module rqgen_channel
    import rqgen_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    input  logic [CNT_W-1:0] req_count,
    input  logic             trig_evt,
    input  logic             dma_served,
    input  logic             ovr_clr,
    input  logic             ovr_ie,
    output logic             dma_req,
    output logic             ovr_flag,
    output logic             ovr_irq
);
    rqgen_state_e state;
    rqgen_ctl_t   ctl;
    logic         last;

    rqgen_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .en     (gen_en),
        .trig   (trig_evt),
        .served (dma_served),
        .last   (last),
        .state  (state),
        .ctl    (ctl)
    );

    rqgen_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.start),
        .dec      (ctl.take),
        .load_val (req_count),
        .last     (last)
    );

    rqgen_ovr u_ovr (
        .clk  (clk),
        .rst  (rst),
        .set  (ctl.ovr_evt),
        .clr  (ovr_clr),
        .ie   (ovr_ie),
        .flag (ovr_flag),
        .irq  (ovr_irq)
    );

    assign dma_req = (state == ST_REQ);
endmodule

// File: rtl/rqgen_channel_chk.sv
module rqgen_channel_chk
    import rqgen_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         gen_en,
    input logic         trig_evt,
    input logic         dma_served,
    input logic         ovr_clr,
    input logic         ovr_ie,
    input logic         dma_req,
    input logic         ovr_flag,
    input logic         ovr_irq,
    input rqgen_state_e state
);
    p_quiet_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> !dma_req);

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        gen_en && trig_evt && state == ST_IDLE |=> dma_req);

    p_drop_after_serve_r4: assert property (@(posedge clk) disable iff (rst)
        gen_en && dma_req && dma_served |=> !dma_req);

    p_gap_return_r4: assert property (@(posedge clk) disable iff (rst)
        gen_en && state == ST_GAP |=> dma_req);

    p_ovr_set_r7: assert property (@(posedge clk) disable iff (rst)
        gen_en && trig_evt && state != ST_IDLE |=> ovr_flag);

    p_ovr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ovr_flag && !ovr_clr |=> ovr_flag);

    p_ovr_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ovr_clr && !(gen_en && trig_evt && state != ST_IDLE) |=> !ovr_flag);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (!ovr_flag || !ovr_ie) |-> !ovr_irq);
endmodule

bind rqgen_channel rqgen_channel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .gen_en     (gen_en),
    .trig_evt   (trig_evt),
    .dma_served (dma_served),
    .ovr_clr    (ovr_clr),
    .ovr_ie     (ovr_ie),
    .dma_req    (dma_req),
    .ovr_flag   (ovr_flag),
    .ovr_irq    (ovr_irq),
    .state      (state)
);

// File: tb/rqgen_channel_test.sv
`timescale 1ns/1ps
module rqgen_channel_test;
    localparam int CNT_W = 5;
    localparam int NVEC  = 5;
    localparam int VEC_CNT [NVEC] = '{0, 2, 5, 1, 31};
    localparam int VEC_DLY [NVEC] = '{0, 1, 3, 2, 0};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             gen_en = 1'b0;
    logic [CNT_W-1:0] req_count = '0;
    logic             trig_evt = 1'b0;
    logic             dma_served = 1'b0;
    logic             ovr_clr = 1'b0;
    logic             ovr_ie = 1'b0;
    logic             dma_req, ovr_flag, ovr_irq;
    int               checks = 0;
    int               errors = 0;

    always #2.5 clk = ~clk;

    rqgen_channel #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .gen_en(gen_en), .req_count(req_count),
        .trig_evt(trig_evt), .dma_served(dma_served), .ovr_clr(ovr_clr),
        .ovr_ie(ovr_ie), .dma_req(dma_req), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig_evt = 1'b1; tick(); trig_evt = 1'b0;
    endtask

    task automatic serve_once();
        dma_served = 1'b1; tick(); dma_served = 1'b0;
    endtask

    task automatic clear_ovr();
        ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
    endtask

    task automatic run_burst(input int delay, output int n);
        int idle = 0;
        int guard = 0;
        n = 0;
        while (idle < 4 && guard < 2000) begin
            guard++;
            if (dma_req) begin
                repeat (delay) tick();
                serve_once();
                n++;
                idle = 0;
            end else begin
                tick();
                idle++;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) tick();
        chk("R1 req in reset", dma_req, 0);
        chk("R1 flag in reset", ovr_flag, 0);
        rst = 1'b0;
        tick();
        chk("R1 req after reset", dma_req, 0);
        chk("R1 irq after reset", ovr_irq, 0);

        // R2: trigger while disabled
        req_count = 5'd3;
        pulse_trig();
        chk("R2 req disabled", dma_req, 0);
        repeat (3) tick();
        chk("R2 req still low", dma_req, 0);
        chk("R2 flag untouched", ovr_flag, 0);

        // R5: table of counts and serve latencies
        gen_en = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            req_count = CNT_W'(VEC_CNT[i]);
            pulse_trig();
            chk("R3 req after trigger", dma_req, 1);
            run_burst(VEC_DLY[i], n);
            chk("R5 burst length", n, VEC_CNT[i] + 1);
            chk("R5 quiet after burst", dma_req, 0);
        end

        // R4 / R6: drop after serve, gap serve ignored
        req_count = 5'd1;
        pulse_trig();
        serve_once();
        chk("R4 req drops after serve", dma_req, 0);
        serve_once();
        chk("R4 req returns after gap", dma_req, 1);
        run_burst(0, n);
        chk("R6 gap serve ignored", n, 1);

        // R7 / R8: overrun during burst, burst continues
        req_count = 5'd3;
        pulse_trig();
        serve_once();
        tick();
        pulse_trig();
        chk("R7 overrun flag set", ovr_flag, 1);
        run_burst(1, n);
        chk("R7 burst remainder kept", n, 3);
        repeat (3) tick();
        chk("R8 flag sticky", ovr_flag, 1);
        ovr_ie = 1'b1;
        #1;
        chk("R9 irq with enable", ovr_irq, 1);
        ovr_ie = 1'b0;
        #1;
        chk("R9 irq gated", ovr_irq, 0);
        clear_ovr();
        chk("R8 flag cleared", ovr_flag, 0);

        // R8: set and clear in the same cycle
        req_count = 5'd2;
        pulse_trig();
        trig_evt = 1'b1; ovr_clr = 1'b1; tick(); trig_evt = 1'b0; ovr_clr = 1'b0;
        chk("R8 set beats clear", ovr_flag, 1);
        run_burst(0, n);
        clear_ovr();
        chk("R8 cleared again", ovr_flag, 0);

        // R10: disable mid burst, then full restart
        req_count = 5'd4;
        pulse_trig();
        serve_once();
        tick();
        gen_en = 1'b0;
        tick();
        chk("R10 req drops on disable", dma_req, 0);
        repeat (3) tick();
        gen_en = 1'b1;
        tick();
        chk("R10 stays idle", dma_req, 0);
        pulse_trig();
        chk("R10 restart req", dma_req, 1);
        chk("R10 no overrun on restart", ovr_flag, 0);
        run_burst(0, n);
        chk("R10 full burst", n, 5);

        // R11: trigger coincides with the last serve
        req_count = 5'd1;
        pulse_trig();
        serve_once();
        tick();
        chk("R11 last request up", dma_req, 1);
        dma_served = 1'b1; trig_evt = 1'b1; tick(); dma_served = 1'b0; trig_evt = 1'b0;
        chk("R11 overrun", ovr_flag, 1);
        chk("R11 burst ended", dma_req, 0);
        repeat (3) tick();
        chk("R11 no new burst", dma_req, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule